// File: doc/BRIEF.md
# Processor Trace Status and Data Port

This block turns per-cycle activity reported by a CPU core into a real-time debug trace on two 4-bit outputs. A status bus carries one code per clock that tells an external probe what the core is doing: starting an ordinary instruction, carrying on with a multi-cycle one, entering user mode, starting a pulse or data-write instruction, taking a branch, returning from an exception, processing an exception, or running in emulator mode. A second 4-bit bus carries values the probe cannot infer on its own, such as branch target addresses and operands written for the debugger, one nibble per clock.

Values to be shown are pushed by the core together with a byte count. They wait in a two-entry buffer. A serializer takes them out one at a time. For each value it first places a byte-count marker on the status bus for one cycle. It then shifts the value out on the data bus, least significant nibble first. When both buffer entries are occupied, the block raises a stall so the core holds off. When a marker takes the status bus in a cycle that also has an instruction status to show, that status is kept and shown in the next free cycle.

Top module: `trace_port`

## Requirements
- R1: With no exception or emulator activity, no marker and no held status, `pst` shows the code for `core_evt`. The mapping is 0 (none or continue) to 0x0, 1 (instruction start) to 0x1, 2 (user-mode entry) to 0x3, 3 (pulse or data-write start) to 0x4, 4 (taken branch) to 0x5, and 5 (return from exception) to 0x7.
- R2: A marker on `pst` is 0x7 plus the byte count, so 0x8 to 0xB stand for 1 to 4 bytes. The count is `push_len`+1 for a push, or `br_len`+1 when the push comes with `core_evt`=4.
- R3: A marker is on `pst` for exactly one cycle that has neither `exc_act` nor `emu_act` high. The first data nibble of the value is on `ddata` in the cycle right after it.
- R4: A value of N bytes shows on `ddata` as 2N consecutive nibbles, least significant first. `ddata` is 0 whenever no nibble is being shown.
- R5: While `exc_act` is high and `emu_act` is low, `pst` is 0xC. A marker that is due is postponed until both are low, and `core_evt` values given in such cycles are discarded.
- R6: While `emu_act` is high, `pst` is 0xD, whatever the state of `exc_act`.
- R7: `stall` is high exactly when two buffered values are waiting. A push made while `stall` is high is ignored.
- R8: A non-zero event given in a marker cycle is shown on `pst` in the next cycle that is not a marker and has neither `exc_act` nor `emu_act` high. Until a cycle with `core_evt`=0 arrives, later events are each shown one cycle late.
- R9: A push into an empty buffer while the serializer is idle puts its marker on `pst` in the next cycle. A push and a drain in the same cycle leave the buffer occupancy unchanged.
- R10: The unused `core_evt` values 6 and 7 have no effect and show as 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_evt | input | 3 | Instruction-level event for this cycle |
| exc_act | input | 1 | Exception processing in progress |
| emu_act | input | 1 | Emulator-mode entry in progress |
| push_en | input | 1 | Queue a value for display |
| push_data | input | DATA_W | Value to display |
| push_len | input | 2 | Byte count minus one for a pushed value |
| br_len | input | 2 | Byte count minus one for branch targets |
| stall | output | 1 | Both buffer entries occupied; core must wait |
| pst | output | 4 | Processor status code |
| ddata | output | 4 | Data nibble |

## Verification
A wrong buffer occupancy shows first on `stall`, in the same cycle. A lost or duplicated entry shows at the next marker slot as a missing marker or a wrong nibble. A serializer count that is off by one lengthens or shortens the nibble run, and the probe sees this on `ddata` within one cycle of the expected end. A held-status register that fails to clear repeats an old code on `pst` in the following cycle.

// File: rtl/trace_port.sv
module trace_port #(
  parameter int DATA_W = 32,
  localparam int NIB   = DATA_W / 4,
  localparam int CNT_W = $clog2(NIB + 1),
  localparam int LEN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        core_evt,
  input  logic              exc_act,
  input  logic              emu_act,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic [LEN_W-1:0]  push_len,
  input  logic [LEN_W-1:0]  br_len,
  output logic              stall,
  output logic [3:0]        pst,
  output logic [3:0]        ddata
);

  function automatic logic [3:0] evt_code_f(input logic [2:0] e);
    case (e)
      3'd1:    return 4'h1;
      3'd2:    return 4'h3;
      3'd3:    return 4'h4;
      3'd4:    return 4'h5;
      3'd5:    return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  logic [DATA_W-1:0] q_val [2];
  logic [LEN_W-1:0]  q_len [2];
  logic [1:0]        occ;

  logic              mark;
  logic [LEN_W-1:0]  mnb;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;

  logic              held_v;
  logic [3:0]        held;

  logic [3:0]        evt_code;
  logic              hold_off, push_ok, ser_free, start;
  logic [LEN_W-1:0]  in_len, head_len;
  logic [DATA_W-1:0] head_val;

  assign evt_code = evt_code_f(core_evt);
  assign hold_off = exc_act | emu_act;
  assign stall    = (occ == 2'd2);
  assign push_ok  = push_en & ~stall;
  assign in_len   = (core_evt == 3'd4) ? br_len : push_len;
  assign ser_free = ~mark & (cnt <= CNT_W'(1));
  assign start    = ser_free & ((occ != 2'd0) | push_ok);
  assign head_val = (occ != 2'd0) ? q_val[0] : push_data;
  assign head_len = (occ != 2'd0) ? q_len[0] : in_len;

  assign pst = emu_act  ? 4'hD :
               exc_act  ? 4'hC :
               mark     ? 4'h8 + 4'(mnb) :
               held_v   ? held : evt_code;

  assign ddata = (cnt != '0) ? sh[3:0] : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= 2'd0;
      for (int i = 0; i < 2; i++) begin
        q_val[i] <= '0;
        q_len[i] <= '0;
      end
    end else begin
      if (start && occ != 2'd0) begin
        q_val[0] <= q_val[1];
        q_len[0] <= q_len[1];
        if (push_ok) begin
          q_val[0] <= push_data;
          q_len[0] <= in_len;
        end
      end else if (!start && push_ok) begin
        q_val[occ[0]] <= push_data;
        q_len[occ[0]] <= in_len;
      end
      occ <= occ + 2'(push_ok) - 2'(start);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark <= 1'b0;
      mnb  <= '0;
      cnt  <= '0;
      sh   <= '0;
    end else if (start) begin
      mark <= 1'b1;
      mnb  <= head_len;
      sh   <= head_val;
      cnt  <= '0;
    end else if (mark && !hold_off) begin
      mark <= 1'b0;
      cnt  <= (CNT_W'(mnb) + CNT_W'(1)) << 1;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      sh  <= sh >> 4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held   <= 4'h0;
    end else if (!hold_off) begin
      if (mark) begin
        if (evt_code != 4'h0) begin
          held_v <= 1'b1;
          held   <= evt_code;
        end
      end else if (held_v) begin
        if (evt_code != 4'h0) held <= evt_code;
        else held_v <= 1'b0;
      end
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 2'd2);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !start) |=> stall);

  // R3
  mark_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pst[3:2] == 2'b10 && !hold_off) |=> (cnt == ((CNT_W'($past(mnb)) + CNT_W'(1)) << 1)));

  // R4
  nibble_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)) && (ddata == $past(sh[7:4])));

  // R5
  defer_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && hold_off) |=> mark);

  // R8
  held_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v && !hold_off && !mark && core_evt == 3'd0) |=> !held_v);

endmodule

// File: tb/trace_port_tb.sv
`timescale 1ns/1ps
module trace_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  core_evt = '0;
  logic        exc_act = 1'b0, emu_act = 1'b0, push_en = 1'b0;
  logic [31:0] push_data = '0;
  logic [1:0]  push_len = '0, br_len = '0;
  logic        stall;
  logic [3:0]  pst, ddata;

  trace_port u_dut (.clk(clk), .rst_n(rst_n), .core_evt(core_evt), .exc_act(exc_act),
    .emu_act(emu_act), .push_en(push_en), .push_data(push_data), .push_len(push_len),
    .br_len(br_len), .stall(stall), .pst(pst), .ddata(ddata));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string note = "";

  typedef struct { logic [31:0] v; int n; } ent_t;
  ent_t        mq[$];
  logic [3:0]  nq[$];
  bit          m_mark = 0, h_v = 0;
  int          m_n = 0;
  logic [31:0] m_v = '0;
  logic [3:0]  h_c = '0;

  function automatic logic [3:0] ecode(logic [2:0] e);
    case (e)
      3'd1: return 4'h1;  3'd2: return 4'h3;  3'd3: return 4'h4;
      3'd4: return 4'h5;  3'd5: return 4'h7;  default: return 4'h0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s%s: actual 0x%0h expected 0x%0h at %0t", tag, note, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [3:0] ep;
    string t;
    bit hold, free;
    #1;
    hold = exc_act | emu_act;
    if (emu_act) begin ep = 4'hD; t = "R6"; end
    else if (exc_act) begin ep = 4'hC; t = "R5"; end
    else if (m_mark) begin ep = 4'(7 + m_n); t = "R2 R3"; end
    else if (h_v) begin ep = h_c; t = "R8"; end
    else begin ep = ecode(core_evt); t = (core_evt > 3'd5) ? "R10" : "R1"; end
    chk(t, pst, ep);
    chk("R4", ddata, nq.size() ? nq[0] : 4'h0);
    chk("R7", stall, mq.size() == 2);
    @(posedge clk);
    free = !m_mark && nq.size() <= 1;
    if (push_en && mq.size() < 2)
      mq.push_back('{push_data, (core_evt == 3'd4) ? int'(br_len) + 1 : int'(push_len) + 1});
    if (!hold) begin
      if (m_mark) begin
        if (ecode(core_evt) != 0) begin h_v = 1; h_c = ecode(core_evt); end
      end else if (h_v) begin
        if (ecode(core_evt) != 0) h_c = ecode(core_evt); else h_v = 0;
      end
    end
    if (m_mark && !hold) begin
      m_mark = 0;
      for (int i = 0; i < 2 * m_n; i++) nq.push_back(4'((m_v >> (4 * i)) & 32'hF));
    end else if (nq.size()) void'(nq.pop_front());
    if (free && mq.size()) begin
      ent_t e = mq.pop_front();
      m_mark = 1; m_n = e.n; m_v = e.v;
    end
    @(negedge clk);
  endtask

  task automatic drive(logic [2:0] ev, bit pe, logic [31:0] d, logic [1:0] ln);
    core_evt = ev; push_en = pe; push_data = d; push_len = ln;
    step();
    core_evt = '0; push_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    note = " reset";
    step();
    note = " R9 wdata";
    drive(3'd3, 1, 32'h8765_4321, 2'd3);
    drive(3'd1, 0, 0, 0);
    repeat (9) step();
    note = " R2 branch";
    br_len = 2'd1;
    drive(3'd4, 1, 32'hDEAD_BEEF, 2'd3);
    repeat (6) step();
    note = " R10";
    drive(3'd6, 0, 0, 0);
    drive(3'd7, 0, 0, 0);
    note = " R7 fill";
    drive(3'd3, 1, 32'h0000_00A5, 2'd0);
    drive(3'd0, 1, 32'h0000_1234, 2'd1);
    drive(3'd0, 1, 32'h00C0_FFEE, 2'd2);
    drive(3'd0, 1, 32'h1111_1111, 2'd3);
    drive(3'd0, 1, 32'h2222_2222, 2'd3);
    repeat (20) step();
    note = " R5 defer";
    drive(3'd3, 1, 32'h0000_0055, 2'd0);
    exc_act = 1; repeat (3) step();
    emu_act = 1; note = " R6"; repeat (2) step();
    exc_act = 0; emu_act = 0; note = " R5 defer";
    repeat (6) step();
    note = "";
    for (int c = 0; c < 4000; c++) begin
      if (!exc_act && !emu_act && $urandom_range(0, 49) == 0) begin
        exc_act = 1; emu_act = $urandom_range(0, 2) == 0;
      end else if ((exc_act || emu_act) && $urandom_range(0, 3) == 0) begin
        exc_act = 0; emu_act = 0;
      end
      core_evt = h_v ? 3'd0 : 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) core_evt = 3'd0;
      push_en   = $urandom_range(0, 9) < 3;
      push_data = $urandom;
      push_len  = 2'($urandom_range(0, 3));
      br_len    = 2'($urandom_range(0, 3));
      step();
    end
    exc_act = 0; emu_act = 0; core_evt = 0; push_en = 0;
    repeat (30) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule